// File: doc/BRIEF.md
# Indirect Execution Control Port

This block is the register-mapped control slave that sits in front of a small embedded execution engine. Software sees three main registers: a data word, an address word and a combined command/status word. Every access to the engine's instruction memory, data memory and execution-context registers goes through them. Software loads the operands, then writes an 8-bit command code. The command either moves a word between the data register and one of the three storage spaces, or performs a run-control action: step, start, stop, clear pipeline or clear profile counter.

Commands are placed in a small queue. Each queued entry is a snapshot of the data and address registers taken when the command was written. While a read is still in flight, the queue holds back later commands until that read completes.

A read result reaches the data register only after a fixed latency. Software therefore polls the data register a few times before the value is trustworthy. The engine core is a stub with the following behaviour:
- It keeps the run, stop, cleared and pipeline-clean flags.
- It counts one completed instruction per step request.
- It counts profile cycles while running.

Top module: `xcp_exec_port`

## Requirements
- R1: After reset the status word reads 0x40800000 (stopped bit 30 and pipeline-clean bit 23 set). The data, address, watch and profile registers all read zero.
- R2: The bus register offsets are as follows:
  - bus_idx 0 is the data register and reads back what was written.
  - bus_idx 1 is the address register and reads back what was written.
  - bus_idx 2 accepts commands (bits [7:0] of the write) and reads back status.
  - bus_idx 3 reads the watch count.
  - bus_idx 4 reads the profile count.
- R3: Commands are executed in arrival order. A command written while a read is pending is held in the queue and not lost, provided no more than QUEUE_DEPTH commands are outstanding. The queue never overflows.
- R4: The storage commands are listed below. Each read returns the last value written to that location of that space, and the three spaces are independent.
  - 0x11 writes instruction memory and 0x10 reads it.
  - 0x13 writes data memory and 0x12 reads it.
  - 0x15 writes the context registers and 0x14 reads them.
- R5: A read command's result is loaded into the data register on the (RD_LAT+1)-th clock edge after the edge that captures the command, provided the queue was idle. Until then the data register keeps its previous value. With RD_LAT=2, the third data-register read taken one per cycle after the command is the first to show the result.
- R6: Addresses wrap. Only the low log2(depth) address bits select a location in each space.
- R7: Start (0x02) does two things:
  - It sets running bit 31 and clears stopped bit 30 and cleared bit 29.
  - It clears bit 31 of context registers 0x04, 0x08 and 0x0C and leaves their other bits unchanged. All other context registers, including 0x00, are untouched.
- R8: Stop (0x03) clears running bit 31 and sets stopped bit 30 on the same clock edge. The two bits are never set together.
- R9: Step (0x01) while not running increments the watch count by exactly one and clears bits 23 and 29. Step while running is ignored. The watch count changes for no other reason.
- R10: Clear pipeline (0x04) sets pipeline-clean bit 23 and cleared bit 29.
- R11: The profile count increments by one on each clock edge while running. Clear profile counter (0x0C) sets it to zero, and the clear takes priority over the increment.
- R12: Command codes not listed above change neither the status, the watch count nor any storage location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_idx | input | 3 | Register index (0 data, 1 address, 2 command/status, 3 watch, 4 profile) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_idx, combinational |
| eng_running | output | 1 | Engine run flag |

## Verification
The checker checks the following on every cycle:
- The run and stopped flags are never both set, and stop sets the stopped flag on the same edge that drops the run flag.
- The watch count only ever moves by one, and only from a non-running state.
- The profile count either clears or advances by one while running.
- The command queue never overflows.

The bench's directed scenarios cover the rest:
- the exact read latency through the data register;
- queued commands surviving a pending read;
- address wrap and the independence of the three storage spaces;
- the selective clearing of context active bits on start;
- the absence of effect from unknown command codes.

// File: rtl/xcp_pkg.sv
package xcp_pkg;

    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // Status word bit positions (software decodes these)
    localparam int ST_RUN_BIT   = 31;
    localparam int ST_HALT_BIT  = 30;
    localparam int ST_CLR_BIT   = 29;
    localparam int ST_CLEAN_BIT = 23;

    // Active flag inside a context level head register
    localparam int CTX_ACTIVE_BIT = 31;

    // Bus register indices
    localparam logic [2:0] IDX_DATA = 3'd0;
    localparam logic [2:0] IDX_ADDR = 3'd1;
    localparam logic [2:0] IDX_CMD  = 3'd2;
    localparam logic [2:0] IDX_WCNT = 3'd3;
    localparam logic [2:0] IDX_PROF = 3'd4;

    typedef enum logic [1:0] {
        SP_INSTR = 2'd0,
        SP_DATA  = 2'd1,
        SP_CTX   = 2'd2
    } space_e;

    typedef enum logic [2:0] {
        EV_NONE     = 3'd0,
        EV_STEP     = 3'd1,
        EV_START    = 3'd2,
        EV_STOP     = 3'd3,
        EV_CLR_PIPE = 3'd4,
        EV_CLR_PROF = 3'd5
    } ctl_ev_e;

    typedef struct packed {
        logic [7:0] code;
        word_t      addr;
        word_t      data;
    } req_t;

    typedef struct packed {
        logic    is_rd;
        logic    is_wr;
        space_e  space;
        ctl_ev_e ev;
    } dec_t;

    function automatic dec_t decode_cmd(input logic [7:0] code);
        dec_t d;
        d.is_rd = 1'b0;
        d.is_wr = 1'b0;
        d.space = SP_INSTR;
        d.ev    = EV_NONE;
        case (code)
            8'h01: d.ev = EV_STEP;
            8'h02: d.ev = EV_START;
            8'h03: d.ev = EV_STOP;
            8'h04: d.ev = EV_CLR_PIPE;
            8'h0C: d.ev = EV_CLR_PROF;
            8'h10: begin d.is_rd = 1'b1; d.space = SP_INSTR; end
            8'h11: begin d.is_wr = 1'b1; d.space = SP_INSTR; end
            8'h12: begin d.is_rd = 1'b1; d.space = SP_DATA;  end
            8'h13: begin d.is_wr = 1'b1; d.space = SP_DATA;  end
            8'h14: begin d.is_rd = 1'b1; d.space = SP_CTX;   end
            8'h15: begin d.is_wr = 1'b1; d.space = SP_CTX;   end
            default: ;
        endcase
        return d;
    endfunction

    // Context level heads that lose their active flag on start
    function automatic logic start_clears(input int idx);
        return (idx == 4) || (idx == 8) || (idx == 12);
    endfunction

    function automatic word_t pack_status(input logic run, input logic halt,
                                          input logic clr, input logic clean);
        word_t s;
        s = '0;
        s[ST_RUN_BIT]   = run;
        s[ST_HALT_BIT]  = halt;
        s[ST_CLR_BIT]   = clr;
        s[ST_CLEAN_BIT] = clean;
        return s;
    endfunction

endpackage

// File: rtl/xcp_req_fifo.sv
module xcp_req_fifo
    import xcp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  req_t wr_req,
    input  logic pop,
    output req_t head,
    output logic empty,
    output logic full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    req_t          slots [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) slots[wptr] <= wr_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/xcp_store.sv
module xcp_store
    import xcp_pkg::*;
#(
    parameter int IMEM_DEPTH = 256,
    parameter int DMEM_DEPTH = 256,
    parameter int CTX_DEPTH  = 32
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  space_e wr_space,
    input  word_t  wr_addr,
    input  word_t  wr_data,
    input  space_e rd_space,
    input  word_t  rd_addr,
    input  logic   start_clr,
    output word_t  rd_data
);

    localparam int IAW = $clog2(IMEM_DEPTH);
    localparam int DAW = $clog2(DMEM_DEPTH);
    localparam int CAW = $clog2(CTX_DEPTH);
    localparam int AW0 = (IAW > DAW) ? IAW : DAW;
    localparam int AW  = (AW0 > CAW) ? AW0 : CAW;

    word_t imem  [IMEM_DEPTH];
    word_t dmem  [DMEM_DEPTH];
    word_t ctx_q [CTX_DEPTH];

    logic [CTX_DEPTH-1:0] clr_mask;
    logic                 unused_addr_hi;

    assign unused_addr_hi = ^{wr_addr[WORD_W-1:AW], rd_addr[WORD_W-1:AW]};

    for (genvar g = 0; g < CTX_DEPTH; g++) begin : g_clr_mask
        assign clr_mask[g] = start_clears(g);
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_space == SP_INSTR) imem[wr_addr[IAW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_space == SP_DATA) dmem[wr_addr[DAW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CTX_DEPTH; i++) ctx_q[i] <= '0;
        end else begin
            for (int i = 0; i < CTX_DEPTH; i++) begin
                if (wr_en && wr_space == SP_CTX && wr_addr[CAW-1:0] == CAW'(i))
                    ctx_q[i] <= wr_data;
                else if (start_clr && clr_mask[i])
                    ctx_q[i][CTX_ACTIVE_BIT] <= 1'b0;
            end
        end
    end

    always_comb begin
        case (rd_space)
            SP_INSTR: rd_data = imem[rd_addr[IAW-1:0]];
            SP_DATA:  rd_data = dmem[rd_addr[DAW-1:0]];
            SP_CTX:   rd_data = ctx_q[rd_addr[CAW-1:0]];
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/xcp_engine_stub.sv
module xcp_engine_stub
    import xcp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ctl_ev_e ev,
    output logic    run,
    output logic    halted,
    output logic    cleared,
    output logic    clean,
    output word_t   watch,
    output word_t   prof
);

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            halted  <= 1'b1;
            cleared <= 1'b0;
            clean   <= 1'b1;
            watch   <= '0;
        end else begin
            case (ev)
                EV_START: begin
                    run     <= 1'b1;
                    halted  <= 1'b0;
                    cleared <= 1'b0;
                end
                EV_STOP: begin
                    run    <= 1'b0;
                    halted <= 1'b1;
                end
                EV_CLR_PIPE: begin
                    clean   <= 1'b1;
                    cleared <= 1'b1;
                end
                EV_STEP: begin
                    if (!run) begin
                        watch   <= watch + 1'b1;
                        clean   <= 1'b0;
                        cleared <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                   prof <= '0;
        else if (ev == EV_CLR_PROF) prof <= '0;
        else if (run)              prof <= prof + 1'b1;
    end

endmodule

// File: rtl/xcp_exec_port.sv
module xcp_exec_port
    import xcp_pkg::*;
#(
    parameter int IMEM_DEPTH  = 256,
    parameter int DMEM_DEPTH  = 256,
    parameter int CTX_DEPTH   = 32,
    parameter int QUEUE_DEPTH = 4,
    parameter int RD_LAT      = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [2:0]  bus_idx,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        eng_running
);

    localparam int LW = $clog2(RD_LAT + 1);

    word_t   data_q, addr_q, hold_q;
    logic [LW-1:0] lat_cnt;
    logic    rd_busy;

    req_t    new_req, head;
    logic    cmd_push, q_pop, q_empty, q_full;
    dec_t    dec;
    ctl_ev_e ev;

    word_t   st_rd_data;
    logic    st_wr_en, st_start_clr;

    logic    eng_run, eng_halt, eng_clr, eng_clean;
    word_t   watch_cnt, prof_cnt;

    assign rd_busy  = (lat_cnt != '0);
    assign cmd_push = bus_we && (bus_idx == IDX_CMD);
    assign new_req  = '{code: bus_wdata[7:0], addr: addr_q, data: data_q};

    xcp_req_fifo #(.DEPTH(QUEUE_DEPTH)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (cmd_push),
        .wr_req(new_req),
        .pop   (q_pop),
        .head  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    assign q_pop        = !q_empty && !rd_busy;
    assign dec          = decode_cmd(head.code);
    assign st_wr_en     = q_pop && dec.is_wr;
    assign st_start_clr = q_pop && (dec.ev == EV_START);
    assign ev           = q_pop ? dec.ev : EV_NONE;

    xcp_store #(
        .IMEM_DEPTH(IMEM_DEPTH),
        .DMEM_DEPTH(DMEM_DEPTH),
        .CTX_DEPTH (CTX_DEPTH)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (st_wr_en),
        .wr_space (dec.space),
        .wr_addr  (head.addr),
        .wr_data  (head.data),
        .rd_space (dec.space),
        .rd_addr  (head.addr),
        .start_clr(st_start_clr),
        .rd_data  (st_rd_data)
    );

    xcp_engine_stub u_engine (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .run    (eng_run),
        .halted (eng_halt),
        .cleared(eng_clr),
        .clean  (eng_clean),
        .watch  (watch_cnt),
        .prof   (prof_cnt)
    );

    // Bus-side registers and read-latency tracking
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            addr_q  <= '0;
            hold_q  <= '0;
            lat_cnt <= '0;
        end else begin
            if (bus_we && bus_idx == IDX_DATA) data_q <= bus_wdata;
            if (bus_we && bus_idx == IDX_ADDR) addr_q <= bus_wdata;
            if (q_pop && dec.is_rd) begin
                hold_q  <= st_rd_data;
                lat_cnt <= LW'(RD_LAT);
            end else if (rd_busy) begin
                lat_cnt <= lat_cnt - 1'b1;
                if (lat_cnt == LW'(1)) data_q <= hold_q;
            end
        end
    end

    always_comb begin
        case (bus_idx)
            IDX_DATA: bus_rdata = data_q;
            IDX_ADDR: bus_rdata = addr_q;
            IDX_CMD:  bus_rdata = pack_status(eng_run, eng_halt, eng_clr, eng_clean);
            IDX_WCNT: bus_rdata = watch_cnt;
            IDX_PROF: bus_rdata = prof_cnt;
            default:  bus_rdata = '0;
        endcase
    end

    assign eng_running = eng_run;

endmodule

// File: rtl/xcp_exec_port_chk.sv
module xcp_exec_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        run,
    input logic        halted,
    input logic [31:0] watch,
    input logic [31:0] prof,
    input logic        push,
    input logic        full
);

    assert_run_halt_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(run && halted));

    assert_stop_same_edge_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(run) |-> halted);

    assert_watch_step_R9: assert property (@(posedge clk) disable iff (rst)
        (watch != $past(watch)) |-> ((watch == $past(watch) + 32'd1) && !$past(run)));

    assert_prof_count_R11: assert property (@(posedge clk) disable iff (rst)
        (prof != $past(prof)) |->
            ((prof == 32'd0) || ((prof == $past(prof) + 32'd1) && $past(run))));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        !(push && full));

endmodule

bind xcp_exec_port xcp_exec_port_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .run   (eng_run),
    .halted(eng_halt),
    .watch (watch_cnt),
    .prof  (prof_cnt),
    .push  (cmd_push),
    .full  (q_full)
);

// File: tb/xcp_exec_port_tb.sv
`timescale 1ns/1ps
module xcp_exec_port_tb;

    localparam int IMEM_DEPTH = 256;
    localparam int DMEM_DEPTH = 256;
    localparam int RD_LAT     = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_idx = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_running;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xcp_exec_port #(.IMEM_DEPTH(IMEM_DEPTH), .DMEM_DEPTH(DMEM_DEPTH), .RD_LAT(RD_LAT)) u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_idx(bus_idx),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_running(eng_running)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] idx, input logic [31:0] val);
        @(negedge clk);
        bus_we = 1'b1; bus_idx = idx; bus_wdata = val;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] idx, output logic [31:0] val);
        bus_idx = idx;
        #1;
        val = bus_rdata;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input logic [7:0] code);
        bus_write(3'd2, {24'd0, code});
    endtask

    task automatic mem_write(input logic [7:0] code, input logic [31:0] a, input logic [31:0] v);
        bus_write(3'd0, v);
        bus_write(3'd1, a);
        issue(code);
        wait_cycles(2);
    endtask

    task automatic mem_read(input logic [7:0] code, input logic [31:0] a, output logic [31:0] v);
        bus_write(3'd1, a);
        issue(code);
        wait_cycles(RD_LAT + 1);
        bus_read(3'd0, v);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        bus_read(3'd2, v); check("R1", "status", v, 32'h4080_0000);
        bus_read(3'd0, v); check("R1", "data", v, 32'h0);
        bus_read(3'd1, v); check("R1", "addr", v, 32'h0);
        bus_read(3'd3, v); check("R1", "watch", v, 32'h0);
        bus_read(3'd4, v); check("R1", "profile", v, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        bus_write(3'd0, 32'h1234_5678);
        bus_write(3'd1, 32'h0000_00A5);
        bus_read(3'd0, v); check("R2", "data readback", v, 32'h1234_5678);
        bus_read(3'd1, v); check("R2", "addr readback", v, 32'h0000_00A5);
    endtask

    task automatic t_mem;
        logic [31:0] v;
        mem_write(8'h11, 32'd3, 32'hA1A1_0003);
        mem_write(8'h13, 32'd3, 32'hB2B2_0003);
        mem_write(8'h15, 32'd3, 32'hC3C3_0003);
        mem_read(8'h10, 32'd3, v); check("R4", "imem read", v, 32'hA1A1_0003);
        mem_read(8'h12, 32'd3, v); check("R4", "dmem read", v, 32'hB2B2_0003);
        mem_read(8'h14, 32'd3, v); check("R4", "ctx read", v, 32'hC3C3_0003);
    endtask

    task automatic t_latency;
        logic [31:0] v;
        mem_write(8'h11, 32'd7, 32'h0BAD_F00D);
        bus_write(3'd0, 32'hDEAD_BEEF);
        bus_write(3'd1, 32'd7);
        issue(8'h10);
        wait_cycles(1); bus_read(3'd0, v); check("R5", "first read", v, 32'hDEAD_BEEF);
        wait_cycles(1); bus_read(3'd0, v); check("R5", "second read", v, 32'hDEAD_BEEF);
        wait_cycles(1); bus_read(3'd0, v); check("R5", "third read", v, 32'h0BAD_F00D);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        mem_write(8'h13, DMEM_DEPTH + 9, 32'h5555_0009);
        mem_read(8'h12, 32'd9, v); check("R6", "dmem wrap", v, 32'h5555_0009);
        mem_write(8'h11, 32'd11, 32'h6666_000B);
        mem_read(8'h10, IMEM_DEPTH * 2 + 11, v); check("R6", "imem wrap", v, 32'h6666_000B);
    endtask

    task automatic t_queue;
        logic [31:0] v, w0;
        mem_write(8'h11, 32'd20, 32'h7777_0014);
        bus_read(3'd3, w0);
        bus_write(3'd1, 32'd20);
        issue(8'h10);
        issue(8'h01);
        issue(8'h01);
        wait_cycles(8);
        bus_read(3'd3, v); check("R3", "queued steps", v, w0 + 32'd2);
        bus_read(3'd0, v); check("R3", "read before queue", v, 32'h7777_0014);
    endtask

    task automatic t_step_clear;
        logic [31:0] v, w0;
        bus_read(3'd3, w0);
        issue(8'h01); wait_cycles(2);
        bus_read(3'd3, v); check("R9", "step increments", v, w0 + 32'd1);
        bus_read(3'd2, v); check("R9", "step status", v, 32'h4000_0000);
        issue(8'h04); wait_cycles(2);
        bus_read(3'd2, v); check("R10", "clear pipe status", v, 32'h6080_0000);
    endtask

    task automatic t_start;
        logic [31:0] v;
        mem_write(8'h15, 32'h00, 32'h8001_2345);
        mem_write(8'h15, 32'h04, 32'h8001_2345);
        mem_write(8'h15, 32'h08, 32'h8001_2345);
        mem_write(8'h15, 32'h0C, 32'h8001_2345);
        mem_write(8'h15, 32'h10, 32'h8001_2345);
        issue(8'h02); wait_cycles(2);
        bus_read(3'd2, v); check("R7", "start status", v, 32'h8080_0000);
        check("R7", "running pin", {31'd0, eng_running}, 32'd1);
        mem_read(8'h14, 32'h04, v); check("R7", "ctx4 cleared", v, 32'h0001_2345);
        mem_read(8'h14, 32'h08, v); check("R7", "ctx8 cleared", v, 32'h0001_2345);
        mem_read(8'h14, 32'h0C, v); check("R7", "ctxC cleared", v, 32'h0001_2345);
        mem_read(8'h14, 32'h00, v); check("R7", "ctx0 kept", v, 32'h8001_2345);
        mem_read(8'h14, 32'h10, v); check("R7", "ctx10 kept", v, 32'h8001_2345);
    endtask

    task automatic t_running;
        logic [31:0] v, w0, p1;
        bus_read(3'd3, w0);
        issue(8'h01); wait_cycles(2);
        bus_read(3'd3, v); check("R9", "step ignored running", v, w0);
        bus_read(3'd4, p1);
        wait_cycles(5);
        bus_read(3'd4, v); check("R11", "profile counts", v, p1 + 32'd5);
        issue(8'h0C); wait_cycles(1);
        bus_read(3'd4, v); check("R11", "profile cleared", v, 32'd0);
    endtask

    task automatic t_stop;
        logic [31:0] v;
        issue(8'h03);
        bus_read(3'd2, v); check("R8", "before stop edge", v, 32'h8080_0000);
        wait_cycles(1);
        bus_read(3'd2, v); check("R8", "stop edge", v, 32'h4080_0000);
    endtask

    task automatic t_unknown;
        logic [31:0] v, w0;
        bus_read(3'd3, w0);
        bus_write(3'd0, 32'hFFFF_FFFF);
        bus_write(3'd1, 32'h04);
        issue(8'h07); issue(8'h16); issue(8'hFF);
        wait_cycles(3);
        bus_read(3'd2, v); check("R12", "status unchanged", v, 32'h4080_0000);
        bus_read(3'd3, v); check("R12", "watch unchanged", v, w0);
        mem_read(8'h14, 32'h04, v); check("R12", "ctx unchanged", v, 32'h0001_2345);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_regs;
        t_mem;
        t_latency;
        t_wrap;
        t_queue;
        t_step_clear;
        t_start;
        t_running;
        t_stop;
        t_unknown;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule